// File: doc/BRIEF.md
# Single-Wire Register Link Host Master

This block is the host end of a half-duplex, one-wire register link. The host side alone starts a frame. A frame opens with a three-bit start pattern whose middle bit lasts exactly one bit period, so the remote side can time the link. A three-bit command comes next, then a five-bit register address and a turnaround guard. Eight data bits follow, then a two-bit complementary parity pair. A write frame then adds a turnaround guard and a two-bit acknowledge from the remote side. Every frame ends with two released trailing guard slots.

A request is handed over on a valid/ready port. `req_ready` is high only while the block is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. While a frame runs, ready stays low, so the requester has to hold or drop its request. Nothing queues. The bit period in clocks and the idle-level setting are sampled when a request is taken. When the frame ends, `done` pulses for one clock. At that point the read data and the two error flags are updated, and they hold their values until the next `done`. The tri-state wire is split into `line_out`, `line_oe` and `line_in` for the pad.

Top module: `swl_host_master`

## Requirements
- R1: A frame begins only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no frame is running. `line_oe` is 0 while idle. A request held high during a frame is not taken and does not alter that frame.
- R2: Each bit slot lasts `bit_period` clocks, and values below 2 act as 2. The start field is driven as 0,1,0 when `idle_high`=1 and as 1,0,1 when `idle_high`=0.
- R3: Slots 3..5 carry the command, 1,1,0 for a read and 0,1,1 for a write. Slots 6..10 carry the address, MSB first. Slot 11 is a guard: it is driven at the idle level on a write and released on a read.
- R4: On a write, slots 12..19 carry the data MSB first. Slot 20 carries P = XOR of the command, address and data bits, and slot 21 carries not-P.
- R5: On a read, the line is released from slot 11 to the end of the frame. `line_in` is sampled in slots 12..21 at clock count `bit_period/2` of each slot, counting from 0. Data arrives MSB first, followed by the two parity bits. `rd_data` receives the data.
- R6: On a read, `parity_err` is 1 when the first returned parity bit differs from the XOR of command 1,1,0, the address and the returned data, or when the two returned parity bits are equal. Otherwise it is 0.
- R7: On a write, slot 22 is released. Slots 23 and 24 are released and sampled as the acknowledge. `ack_err` is 1 unless the acknowledge equals the parity pair that was sent.
- R8: Two released trailing guard slots end every frame, giving 24 slots for a read and 27 for a write. `done` rises in the clock after the last guard slot ends, and `req_ready` returns in that same cycle.
- R9: `bit_period` and `idle_high` are captured when a request is taken. Changing them during a frame has no effect on that frame.
- R10: `done` lasts one clock. A write leaves `rd_data` unchanged and clears `parity_err`. A read clears `ack_err`. All results hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write data |
| bit_period | input | 16 | Clocks per bit slot |
| idle_high | input | 1 | Idle level of the line, selects the start pattern |
| rd_data | output | 8 | Data returned by the last read |
| done | output | 1 | One-clock frame completion pulse |
| parity_err | output | 1 | Read parity check failed |
| ack_err | output | 1 | Write acknowledge mismatch |
| line_in | input | 1 | Sensed level of the wire |
| line_out | output | 1 | Level driven onto the wire |
| line_oe | output | 1 | Drive enable for the wire |

## Verification
The bench keeps the default widths: 5 address bits, 8 data bits and a 16-bit period field. It changes the bit period from frame to frame, between 0 and 9. Period values 0 and 1 fall on the clamp to 2, and at that length the mid-slot sample lands on the final clock of the slot. Odd periods test how the mid-point is rounded. Read and write frames are mixed, including frames with a corrupted parity bit or acknowledge bit, frames with new requests held high while the frame is busy, and frames whose configuration changes mid-frame.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam logic [2:0] CMD_RD  = 3'b110;
  localparam logic [2:0] CMD_WR  = 3'b011;
  localparam int START_W = 3;
  localparam int CMD_W   = 3;
  localparam int PAR_W   = 2;
  localparam int TURN_W  = 1;
  localparam int ACK_W   = 2;
  localparam int TAIL_W  = 2;
endpackage

// File: rtl/swl_bit_timer.sv
module swl_bit_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             at_mid,
  output logic             at_end
);
  logic [PER_W-1:0] cnt;

  assign at_end = run && (cnt == period - PER_W'(1));
  assign at_mid = run && (cnt == (period >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= at_end ? '0 : cnt + PER_W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period)); // R2
endmodule

// File: rtl/swl_frame_build.sv
module swl_frame_build import swl_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int FR_W   = START_W + CMD_W + ADDR_W + 1 + DATA_W + PAR_W + TURN_W + ACK_W + TAIL_W
) (
  input  logic              wr,
  input  logic              idle_high,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FR_W-1:0]   tx_vec,
  output logic [FR_W-1:0]   oe_vec,
  output logic [FR_W-1:0]   smp_vec
);
  localparam int HDR_W   = START_W + CMD_W + ADDR_W;
  localparam int BODY_W  = 1 + DATA_W + PAR_W;
  localparam int WTAIL_W = TURN_W + ACK_W + TAIL_W;

  logic [2:0] start_pat;
  logic [2:0] cmd;
  logic       par;

  assign start_pat = idle_high ? 3'b010 : 3'b101;
  assign cmd       = wr ? CMD_WR : CMD_RD;
  assign par       = ^{cmd, addr, wdata};

  always_comb begin
    if (wr) begin
      tx_vec  = {start_pat, cmd, addr, idle_high, wdata, par, ~par,
                 idle_high, {ACK_W{1'b0}}, {TAIL_W{idle_high}}};
      oe_vec  = {{(HDR_W + BODY_W){1'b1}}, {WTAIL_W{1'b0}}};
      smp_vec = {{(HDR_W + BODY_W + TURN_W){1'b0}}, {ACK_W{1'b1}}, {TAIL_W{1'b0}}};
    end else begin
      tx_vec  = {start_pat, cmd, addr, {(FR_W - HDR_W){idle_high}}};
      oe_vec  = {{HDR_W{1'b1}}, {(FR_W - HDR_W){1'b0}}};
      smp_vec = {{(HDR_W + 1){1'b0}}, {(DATA_W + PAR_W){1'b1}}, {WTAIL_W{1'b0}}};
    end
  end
endmodule

// File: rtl/swl_rx_check.sv
module swl_rx_check import swl_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_bad,
  output logic              ack_bad
);
  localparam int RX_W = DATA_W + PAR_W;

  logic [RX_W-1:0] sh;
  logic            rd_par_exp;
  logic            wr_par_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (clear)    sh <= '0;
    else if (shift_en) sh <= {sh[RX_W-2:0], din};
  end

  assign rx_data     = sh[RX_W-1:PAR_W];
  assign rd_par_exp  = ^{CMD_RD, addr, rx_data};
  assign wr_par_sent = ^{CMD_WR, addr, wdata};
  assign rx_par_bad  = (sh[1] != rd_par_exp) || (sh[1] == sh[0]);
  assign ack_bad     = (sh[1:0] != {wr_par_sent, ~wr_par_sent});
endmodule

// File: rtl/swl_host_master.sv
module swl_host_master import swl_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PER_W-1:0]  bit_period,
  input  logic              idle_high,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              parity_err,
  output logic              ack_err,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_oe
);
  localparam int HDR_W  = START_W + CMD_W + ADDR_W;
  localparam int BODY_W = 1 + DATA_W + PAR_W;
  localparam int FR_W   = HDR_W + BODY_W + TURN_W + ACK_W + TAIL_W;
  localparam int RD_LEN = HDR_W + BODY_W + TAIL_W;
  localparam int SLOT_W = $clog2(FR_W + 1);

  logic              busy;
  logic              wr_q;
  logic              idle_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  per_in;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] last_slot;
  logic [FR_W-1:0]   tx_q, oe_q, smp_q;
  logic [FR_W-1:0]   tx_n, oe_n, smp_n;
  logic              accept, at_mid, at_end, frame_end;
  logic              done_q, perr_q, aerr_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rx_data;
  logic              rx_par_bad, ack_bad;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign per_in    = (bit_period < PER_W'(2)) ? PER_W'(2) : bit_period;
  assign last_slot = wr_q ? SLOT_W'(FR_W - 1) : SLOT_W'(RD_LEN - 1);
  assign frame_end = busy && at_end && (slot_q == last_slot);

  swl_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FR_W(FR_W)) i_build (
    .wr(req_write), .idle_high(idle_high), .addr(req_addr), .wdata(req_wdata),
    .tx_vec(tx_n), .oe_vec(oe_n), .smp_vec(smp_n)
  );

  swl_bit_timer #(.PER_W(PER_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept),
    .period(per_q), .at_mid(at_mid), .at_end(at_end)
  );

  swl_rx_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .shift_en(busy && at_mid && smp_q[FR_W-1]), .din(line_in),
    .addr(addr_q), .wdata(wdata_q),
    .rx_data(rx_data), .rx_par_bad(rx_par_bad), .ack_bad(ack_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;  wr_q <= 1'b0;  idle_q <= 1'b0;
      addr_q <= '0;  wdata_q <= '0; per_q <= PER_W'(2);
      slot_q <= '0;  tx_q <= '0;    oe_q <= '0;  smp_q <= '0;
      done_q <= 1'b0; perr_q <= 1'b0; aerr_q <= 1'b0; rd_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        wr_q    <= req_write;
        idle_q  <= idle_high;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        per_q   <= per_in;
        slot_q  <= '0;
        tx_q    <= tx_n;
        oe_q    <= oe_n;
        smp_q   <= smp_n;
      end else if (busy && at_end) begin
        if (frame_end) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          if (wr_q) begin
            aerr_q <= ack_bad;
            perr_q <= 1'b0;
          end else begin
            rd_q   <= rx_data;
            perr_q <= rx_par_bad;
            aerr_q <= 1'b0;
          end
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
          tx_q   <= {tx_q[FR_W-2:0], 1'b0};
          oe_q   <= {oe_q[FR_W-2:0], 1'b0};
          smp_q  <= {smp_q[FR_W-2:0], 1'b0};
        end
      end
    end
  end

  assign line_oe    = busy && oe_q[FR_W-1];
  assign line_out   = tx_q[FR_W-1];
  assign done       = done_q;
  assign rd_data    = rd_q;
  assign parity_err = perr_q;
  assign ack_err    = aerr_q;

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R1
  AST_OE_AT_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(at_end)) |-> $stable(line_oe)); // R2
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(per_q) && $stable(idle_q))); // R9
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/test_swl_host_master.sv
module test_swl_host_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [15:0] bit_period = 16'd4;
  logic        idle_high = 1'b1;
  logic [7:0]  rd_data;
  logic        done, parity_err, ack_err;
  logic        line_in, line_out, line_oe;
  logic        dev_oe = 1'b0, dev_v = 1'b0, pull_lvl = 1'b1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] last_rd = '0;

  always #2 clk = ~clk;

  assign line_in = line_oe ? line_out : (dev_oe ? dev_v : pull_lvl);

  swl_host_master i_swl_host_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bit_period(bit_period), .idle_high(idle_high), .rd_data(rd_data),
    .done(done), .parity_err(parity_err), .ack_err(ack_err),
    .line_in(line_in), .line_out(line_out), .line_oe(line_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit par_of(input bit wr, input logic [4:0] a, input logic [7:0] d);
    logic [2:0] c;
    c = wr ? 3'b011 : 3'b110;
    return ^{c, a, d};
  endfunction

  // expected host drive per slot: {oe, value}
  function automatic logic [1:0] exp_drv(input int s, input bit wr, input logic [4:0] a,
                                         input logic [7:0] d, input bit idl);
    logic [2:0] c;
    c = wr ? 3'b011 : 3'b110;
    if (s < 3)       return {1'b1, (s == 1) ? idl : ~idl};
    else if (s < 6)  return {1'b1, c[5-s]};
    else if (s < 11) return {1'b1, a[10-s]};
    else if (s == 11) return {wr, idl};
    else if (s < 20) return {wr, d[19-s]};
    else if (s == 20) return {wr, par_of(wr, a, d)};
    else if (s == 21) return {wr, ~par_of(wr, a, d)};
    return 2'b00;
  endfunction

  // crp: 0 clean, 1 flip first returned bit, 2 flip second
  task automatic run_txn(input bit wr, input logic [4:0] a, input logic [7:0] d,
                         input bit idl, input int per, input int crp,
                         input bit poke, input bit cfgchg);
    int pe, nslots, mid;
    int e_st, e_ca, e_wd, e_rel, e_first;
    logic [7:0] rdat;
    bit p, rp1, rp2;
    logic [1:0] ed;
    pe = (per < 2) ? 2 : per;
    mid = pe / 2;
    nslots = wr ? 27 : 24;
    rdat = 8'($urandom);
    p = par_of(wr, a, wr ? d : rdat);
    rp1 = p ^ (crp == 1);
    rp2 = ~p ^ (crp == 2);
    e_st = 0; e_ca = 0; e_wd = 0; e_rel = 0; e_first = 0;

    @(negedge clk);
    bit_period = 16'(per); idle_high = idl; pull_lvl = idl;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R1 ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0 && done === 1'b0, "R1 ready drops once taken", int'(req_ready), 0);

    for (int s = 0; s < nslots; s++) begin
      for (int c = 0; c < pe; c++) begin
        if (c == 0) begin
          dev_oe = 1'b0;
          if (!wr && s >= 12 && s <= 19) begin dev_oe = 1'b1; dev_v = rdat[19-s]; end
          if (!wr && s == 20) begin dev_oe = 1'b1; dev_v = rp1; end
          if (!wr && s == 21) begin dev_oe = 1'b1; dev_v = rp2; end
          if (wr && s == 23) begin dev_oe = 1'b1; dev_v = rp1; end
          if (wr && s == 24) begin dev_oe = 1'b1; dev_v = rp2; end
          if (poke && s == 5) begin
            req_valid = 1'b1; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
          end
          if (poke && s == nslots - 2) req_valid = 1'b0;
          if (cfgchg && s == 4) begin bit_period = 16'(per + 3); idle_high = ~idl; end
        end
        if (c == mid) begin
          ed = exp_drv(s, wr, a, d, idl);
          if (line_oe !== ed[1] || (ed[1] && line_out !== ed[0])) begin
            if (s < 3) e_st++;
            else if (s < 12) e_ca++;
            else if (wr && s < 22) e_wd++;
            else e_rel++;
            if (e_first == 0) e_first = s + 1000 * int'({line_oe, line_out});
          end
          if (req_ready !== 1'b0) e_rel++;
        end
        @(negedge clk);
      end
    end
    dev_oe = 1'b0;
    chk(e_st == 0, "R2 start field/timing", e_first, 0);
    chk(e_ca == 0, "R3 command/address/guard", e_first, 0);
    if (wr) chk(e_wd == 0, "R4 write data/parity", e_first, 0);
    chk(e_rel == 0, wr ? "R7 turnaround/ack release" : "R5 read release", e_first, 0);
    chk(done === 1'b1 && req_ready === 1'b1, "R8 done after trailing guards",
        int'({done, req_ready}), 3);
    if (wr) begin
      chk(ack_err === (crp != 0), "R7 ack_err", int'(ack_err), int'(crp != 0));
      chk(parity_err === 1'b0 && rd_data === last_rd, "R10 write keeps rd_data",
          int'(rd_data), int'(last_rd));
    end else begin
      chk(rd_data === rdat, "R5 rd_data", int'(rd_data), int'(rdat));
      chk(parity_err === (crp != 0), "R6 parity_err", int'(parity_err), int'(crp != 0));
      chk(ack_err === 1'b0, "R10 read clears ack_err", int'(ack_err), 0);
      last_rd = rdat;
    end
    if (poke || cfgchg) chk(e_st + e_ca + e_wd + e_rel == 0,
        poke ? "R1 busy request ignored" : "R9 config held", e_first, 0);
    @(negedge clk);
    chk(done === 1'b0 && line_oe === 1'b0, "R10 done one clock", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && line_oe === 1'b0 && rd_data === 8'h00
        && parity_err === 1'b0 && ack_err === 1'b0, "R1 reset state",
        int'({req_ready, done, line_oe}), 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_oe === 1'b0, "R1 idle released", int'(line_oe), 0);

    run_txn(1'b0, 5'h15, 8'h00, 1'b1, 2, 0, 1'b0, 1'b0);   // min period, R2
    run_txn(1'b1, 5'h1F, 8'hFF, 1'b0, 3, 0, 1'b0, 1'b0);   // odd period, R4
    run_txn(1'b1, 5'h00, 8'h00, 1'b1, 0, 0, 1'b0, 1'b0);   // clamp to 2, R2
    run_txn(1'b0, 5'h0A, 8'h00, 1'b0, 5, 1, 1'b0, 1'b0);   // R6 flip first
    run_txn(1'b0, 5'h11, 8'h00, 1'b1, 4, 2, 1'b0, 1'b0);   // R6 equal pair
    run_txn(1'b1, 5'h07, 8'hA5, 1'b1, 4, 1, 1'b0, 1'b0);   // R7 bad ack
    run_txn(1'b1, 5'h03, 8'h5A, 1'b0, 6, 2, 1'b0, 1'b0);   // R7 bad ack
    run_txn(1'b0, 5'h1C, 8'h00, 1'b1, 4, 0, 1'b1, 1'b0);   // R1 poke
    run_txn(1'b1, 5'h09, 8'h3C, 1'b0, 5, 0, 1'b0, 1'b1);   // R9
    run_txn(1'b0, 5'h12, 8'h00, 1'b1, 1, 0, 1'b0, 1'b1);   // R9 clamp

    for (int i = 0; i < 60; i++) begin
      run_txn(1'($urandom), 5'($urandom), 8'($urandom), 1'($urandom),
              int'($urandom_range(0, 9)), int'($urandom_range(0, 3)) % 3,
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule